// File: doc/BRIEF.md
# Cache Line Hazard Checker

This block decides whether a request that has reached the last stage of one of two cache pipelines has to step aside and be replayed. It looks at the other outstanding work that could touch the same cache line. That work is the request queue of the candidate's own pipeline, every stage of both pipelines, the miss-wait entries that each pipeline holds while memory is fetched, and two overflow wait entries shared by both pipelines. The result is a single flag, `yield`. The surrounding controller uses it to put the request back in its queue. This block does not do the replay and does not look up any tags.

Line addresses are compared after the offset bits inside a line are dropped. A candidate whose line address is all ones acts as a wildcard and matches every line. Priorities are numbers where a smaller value means a more urgent request. The rules are deliberately asymmetric. The final stage of the other pipeline blocks on a line match whatever its priority. A refill request in flight blocks every request that is not itself a refill, whatever its address. The output is purely combinational.

Top module: `line_hazard_check`

## Requirements
- R1: Two addresses fall on the same line when they differ only in their low log2(LINE_BYTES) bits; a difference above those bits makes them distinct lines.
- R2: A candidate whose line address (address shifted right by log2(LINE_BYTES)) is all ones matches every line, in every comparison that uses a line match.
- R3: The candidate yields to a valid entry of its own request queue on the same line only when the candidate priority number is strictly larger than that entry's.
- R4: The candidate yields to a valid request in the final stage (index NSTAGE-1) of the other pipeline on the same line, whatever the two priorities are.
- R5: The candidate yields to a valid miss-wait entry of either pipeline on the same line only when the candidate priority number is strictly larger than the entry's.
- R6: Request kinds are coded load=0, store=1, invalidate=2, preload=3, unlock=4, refill=5. A candidate that is not a refill yields to any valid refill-kind stage of either pipeline, whatever the address. A refill candidate is not blocked this way.
- R7: A candidate that is not a refill yields to a valid same-line stage of its own pipeline with a strictly smaller priority number. A refill candidate never yields for this reason.
- R8: The candidate yields to either valid shared overflow entry on the same line only when the candidate priority number is strictly larger than the entry's.
- R9: Entries and stages whose valid bit is low have no effect on `yield`; with nothing valid, `yield` is 0.
- R10: `yield` is a combinational function of the present inputs and follows a change of inputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cand_addr | input | ADDR_W | Byte address of the candidate request |
| cand_prio | input | PRIO_W | Candidate priority number (smaller is more urgent) |
| cand_kind | input | 3 | Candidate request kind code |
| cand_pipe | input | 1 | Pipeline holding the candidate (0 or 1) |
| q_vld | input | QDEPTH | Valid bits of the candidate pipeline's request queue |
| q_addr | input | QDEPTH x ADDR_W | Queue entry addresses |
| q_prio | input | QDEPTH x PRIO_W | Queue entry priorities |
| stg_vld | input | 2*NSTAGE | Stage valid bits, index pipe*NSTAGE+stage |
| stg_addr | input | 2*NSTAGE x ADDR_W | Stage addresses |
| stg_prio | input | 2*NSTAGE x PRIO_W | Stage priorities |
| stg_kind | input | 2*NSTAGE x 3 | Stage request kind codes |
| miss_vld | input | 2*NMISS | Miss-wait valid bits, index pipe*NMISS+slot |
| miss_addr | input | 2*NMISS x ADDR_W | Miss-wait addresses |
| miss_prio | input | 2*NMISS x PRIO_W | Miss-wait priorities |
| ovf_vld | input | 2 | Shared overflow entry valid bits |
| ovf_addr | input | 2 x ADDR_W | Overflow entry addresses |
| ovf_prio | input | 2 x PRIO_W | Overflow entry priorities |
| yield | output | 1 | High when the candidate must step aside |

## Verification
The assertions assume that the candidate occupies its own final stage. That stage therefore carries the candidate's priority, and it cannot outrank the candidate or, for a non-refill candidate, count as a refill. The stimulus keeps to this. Every pattern either leaves the candidate's own final stage invalid or fills it with the candidate's own address, priority and kind. Kind codes are only ever driven from the six defined values. Each pattern is applied as one complete set of inputs before `yield` is compared, so the checks never observe a half-updated input set.

// File: rtl/hz_pkg.sv
package hz_pkg;

  localparam logic [2:0] K_LOAD   = 3'd0;
  localparam logic [2:0] K_STORE  = 3'd1;
  localparam logic [2:0] K_INVAL  = 3'd2;
  localparam logic [2:0] K_PRELD  = 3'd3;
  localparam logic [2:0] K_UNLOCK = 3'd4;
  localparam logic [2:0] K_REFILL = 3'd5;

  // Line index of a byte address: offset bits inside the line dropped.
  function automatic logic [63:0] line_idx(input logic [63:0] a, input int unsigned lsb);
    return a >> lsb;
  endfunction

  // True when the candidate line equals the all-ones line of an aw-bit address.
  function automatic logic is_wild(input logic [63:0] a, input int unsigned aw,
                                   input int unsigned lsb);
    logic [63:0] top;
    top = (64'd1 << (aw - lsb)) - 64'd1;
    return line_idx(a, lsb) == top;
  endfunction

  // Candidate/other line match, with the wildcard folded in.
  function automatic logic line_hit(input logic [63:0] cand, input logic [63:0] other,
                                    input int unsigned aw, input int unsigned lsb);
    return (line_idx(cand, lsb) == line_idx(other, lsb)) || is_wild(cand, aw, lsb);
  endfunction

  // Candidate is less urgent than the other request (larger number).
  function automatic logic outranked(input logic [15:0] cand_p, input logic [15:0] other_p);
    return cand_p > other_p;
  endfunction

endpackage

// File: rtl/hz_entry_scan.sv
module hz_entry_scan
  import hz_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PRIO_W     = 8,
  parameter int LINE_BYTES = 32,
  parameter int N          = 4
) (
  input  logic [ADDR_W-1:0]         cand_addr,
  input  logic [PRIO_W-1:0]         cand_prio,
  input  logic [N-1:0]              vld,
  input  logic [N-1:0][ADDR_W-1:0]  addr,
  input  logic [N-1:0][PRIO_W-1:0]  prio,
  output logic                      hit
);
  localparam int unsigned LSB = $clog2(LINE_BYTES);

  logic [N-1:0] ent_hit;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign ent_hit[i] = vld[i]
                      && line_hit(64'(cand_addr), 64'(addr[i]), ADDR_W, LSB)
                      && outranked(16'(cand_prio), 16'(prio[i]));
  end

  assign hit = |ent_hit;
endmodule

// File: rtl/hz_stage_scan.sv
module hz_stage_scan
  import hz_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PRIO_W     = 8,
  parameter int LINE_BYTES = 32,
  parameter int NSTAGE     = 4
) (
  input  logic [ADDR_W-1:0]                cand_addr,
  input  logic [PRIO_W-1:0]                cand_prio,
  input  logic [2:0]                       cand_kind,
  input  logic                             cand_pipe,
  input  logic [2*NSTAGE-1:0]              stg_vld,
  input  logic [2*NSTAGE-1:0][ADDR_W-1:0]  stg_addr,
  input  logic [2*NSTAGE-1:0][PRIO_W-1:0]  stg_prio,
  input  logic [2*NSTAGE-1:0][2:0]         stg_kind,
  output logic                             hit_xpipe,
  output logic                             hit_refill,
  output logic                             hit_own
);
  localparam int unsigned LSB = $clog2(LINE_BYTES);
  localparam int NS = 2 * NSTAGE;

  logic [NS-1:0] x_v, r_v, o_v;
  logic          cand_fill;

  assign cand_fill = (cand_kind == K_REFILL);

  for (genvar p = 0; p < 2; p++) begin : g_pipe
    for (genvar s = 0; s < NSTAGE; s++) begin : g_stg
      localparam int I = p * NSTAGE + s;
      logic same_line, own;
      assign same_line = line_hit(64'(cand_addr), 64'(stg_addr[I]), ADDR_W, LSB);
      assign own       = (cand_pipe == 1'(p));

      if (s == NSTAGE - 1) begin : g_last
        assign x_v[I] = stg_vld[I] && !own && same_line;
      end else begin : g_mid
        assign x_v[I] = 1'b0;
      end

      assign r_v[I] = stg_vld[I] && (stg_kind[I] == K_REFILL) && !cand_fill;
      assign o_v[I] = stg_vld[I] && own && same_line && !cand_fill
                    && outranked(16'(cand_prio), 16'(stg_prio[I]));
    end
  end

  assign hit_xpipe  = |x_v;
  assign hit_refill = |r_v;
  assign hit_own    = |o_v;
endmodule

// File: rtl/line_hazard_check.sv
module line_hazard_check
  import hz_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PRIO_W     = 8,
  parameter int LINE_BYTES = 32,
  parameter int QDEPTH     = 4,
  parameter int NSTAGE     = 4,
  parameter int NMISS      = 2
) (
  input  logic [ADDR_W-1:0]                 cand_addr,
  input  logic [PRIO_W-1:0]                 cand_prio,
  input  logic [2:0]                        cand_kind,
  input  logic                              cand_pipe,
  input  logic [QDEPTH-1:0]                 q_vld,
  input  logic [QDEPTH-1:0][ADDR_W-1:0]     q_addr,
  input  logic [QDEPTH-1:0][PRIO_W-1:0]     q_prio,
  input  logic [2*NSTAGE-1:0]               stg_vld,
  input  logic [2*NSTAGE-1:0][ADDR_W-1:0]   stg_addr,
  input  logic [2*NSTAGE-1:0][PRIO_W-1:0]   stg_prio,
  input  logic [2*NSTAGE-1:0][2:0]          stg_kind,
  input  logic [2*NMISS-1:0]                miss_vld,
  input  logic [2*NMISS-1:0][ADDR_W-1:0]    miss_addr,
  input  logic [2*NMISS-1:0][PRIO_W-1:0]    miss_prio,
  input  logic [1:0]                        ovf_vld,
  input  logic [1:0][ADDR_W-1:0]            ovf_addr,
  input  logic [1:0][PRIO_W-1:0]            ovf_prio,
  output logic                              yield
);
  // Named hazard sources, brought out for the checker.
  logic hit_queue, hit_miss, hit_ovf;
  logic hit_xpipe, hit_refill, hit_own;

  hz_entry_scan #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .LINE_BYTES(LINE_BYTES), .N(QDEPTH))
  u_queue (
    .cand_addr(cand_addr), .cand_prio(cand_prio),
    .vld(q_vld), .addr(q_addr), .prio(q_prio), .hit(hit_queue)
  );

  hz_entry_scan #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .LINE_BYTES(LINE_BYTES), .N(2*NMISS))
  u_miss (
    .cand_addr(cand_addr), .cand_prio(cand_prio),
    .vld(miss_vld), .addr(miss_addr), .prio(miss_prio), .hit(hit_miss)
  );

  hz_entry_scan #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .LINE_BYTES(LINE_BYTES), .N(2))
  u_ovf (
    .cand_addr(cand_addr), .cand_prio(cand_prio),
    .vld(ovf_vld), .addr(ovf_addr), .prio(ovf_prio), .hit(hit_ovf)
  );

  hz_stage_scan #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .LINE_BYTES(LINE_BYTES), .NSTAGE(NSTAGE))
  u_stage (
    .cand_addr(cand_addr), .cand_prio(cand_prio), .cand_kind(cand_kind),
    .cand_pipe(cand_pipe),
    .stg_vld(stg_vld), .stg_addr(stg_addr), .stg_prio(stg_prio), .stg_kind(stg_kind),
    .hit_xpipe(hit_xpipe), .hit_refill(hit_refill), .hit_own(hit_own)
  );

  assign yield = hit_queue | hit_miss | hit_ovf | hit_xpipe | hit_refill | hit_own;
endmodule

// File: rtl/line_hazard_check_sva.sv
module line_hazard_check_sva #(
  parameter int ADDR_W     = 32,
  parameter int PRIO_W     = 8,
  parameter int LINE_BYTES = 32,
  parameter int QDEPTH     = 4,
  parameter int NSTAGE     = 4,
  parameter int NMISS      = 2
) (
  input logic [ADDR_W-1:0]                 cand_addr,
  input logic [PRIO_W-1:0]                 cand_prio,
  input logic [2:0]                        cand_kind,
  input logic                              cand_pipe,
  input logic [QDEPTH-1:0]                 q_vld,
  input logic [2*NSTAGE-1:0]               stg_vld,
  input logic [2*NSTAGE-1:0][ADDR_W-1:0]   stg_addr,
  input logic [2*NSTAGE-1:0][2:0]          stg_kind,
  input logic [2*NMISS-1:0]                miss_vld,
  input logic [1:0]                        ovf_vld,
  input logic                              hit_miss,
  input logic                              hit_ovf,
  input logic                              hit_own,
  input logic                              hit_refill,
  input logic                              yield
);
  localparam int LSB = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-LSB-1:0] ALL1 = '1;

  int   oi;
  logic x_match, wild, any_fill, any_vld;

  always_comb begin
    oi       = cand_pipe ? (NSTAGE - 1) : (2 * NSTAGE - 1);
    wild     = (cand_addr[ADDR_W-1:LSB] == ALL1);
    x_match  = stg_vld[oi] && (wild || cand_addr[ADDR_W-1:LSB] == stg_addr[oi][ADDR_W-1:LSB]);
    any_fill = 1'b0;
    for (int i = 0; i < 2 * NSTAGE; i++)
      if (stg_vld[i] && stg_kind[i] == 3'd5) any_fill = 1'b1;
    any_vld  = (|q_vld) || (|stg_vld) || (|miss_vld) || (|ovf_vld);

    // R4 (R1 line match, R2 wildcard): other pipe's final stage always blocks
    a_r4_xpipe_blocks: assert (!x_match || yield)
      else $error("a_r4_xpipe_blocks");
    // R2: wildcard candidate with any valid other-pipe final stage must yield
    a_r2_wild_xpipe: assert (!(wild && stg_vld[oi]) || yield)
      else $error("a_r2_wild_xpipe");
    // R6: any refill stage blocks a non-refill candidate
    a_r6_refill_blocks: assert (!(any_fill && cand_kind != 3'd5) || yield)
      else $error("a_r6_refill_blocks");
    // R7 (and R6): a refill candidate is never held by stage-kind or own-stage rules
    a_r7_refill_exempt: assert (!(cand_kind == 3'd5) || (!hit_own && !hit_refill))
      else $error("a_r7_refill_exempt");
    // R5: a miss-wait hazard needs a valid miss-wait entry
    a_r5_miss_needs_valid: assert (!hit_miss || (|miss_vld))
      else $error("a_r5_miss_needs_valid");
    // R8: an overflow hazard needs a valid overflow entry
    a_r8_ovf_needs_valid: assert (!hit_ovf || (|ovf_vld))
      else $error("a_r8_ovf_needs_valid");
    // R9: nothing valid, no yield
    a_r9_idle_no_yield: assert (any_vld || !yield)
      else $error("a_r9_idle_no_yield");
  end
endmodule

bind line_hazard_check line_hazard_check_sva #(
  .ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .LINE_BYTES(LINE_BYTES),
  .QDEPTH(QDEPTH), .NSTAGE(NSTAGE), .NMISS(NMISS)
) u_sva (.*);

// File: tb/line_hazard_check_tb.sv
`timescale 1ns/1ps
module line_hazard_check_tb;
  localparam int AW = 32, PW = 8, LB = 32, QD = 4, NS = 4, NM = 2;
  localparam longint WILD_LINE = (64'd1 << AW) / LB - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [AW-1:0]             cand_addr;
  logic [PW-1:0]             cand_prio;
  logic [2:0]                cand_kind;
  logic                      cand_pipe;
  logic [QD-1:0]             q_vld;
  logic [QD-1:0][AW-1:0]     q_addr;
  logic [QD-1:0][PW-1:0]     q_prio;
  logic [2*NS-1:0]           stg_vld;
  logic [2*NS-1:0][AW-1:0]   stg_addr;
  logic [2*NS-1:0][PW-1:0]   stg_prio;
  logic [2*NS-1:0][2:0]      stg_kind;
  logic [2*NM-1:0]           miss_vld;
  logic [2*NM-1:0][AW-1:0]   miss_addr;
  logic [2*NM-1:0][PW-1:0]   miss_prio;
  logic [1:0]                ovf_vld;
  logic [1:0][AW-1:0]        ovf_addr;
  logic [1:0][PW-1:0]        ovf_prio;
  logic                      yield;

  line_hazard_check #(.ADDR_W(AW), .PRIO_W(PW), .LINE_BYTES(LB),
                      .QDEPTH(QD), .NSTAGE(NS), .NMISS(NM)) u_dut (.*);

  typedef struct { bit exp; string tag; } item_t;
  item_t exp_q[$];
  int checks = 0;
  int errors = 0;

  // ---------- reference model, written from the requirements ----------
  function automatic longint ln(input logic [AW-1:0] a);
    return longint'(a) / LB;
  endfunction
  function automatic bit same(input logic [AW-1:0] a);
    return (ln(cand_addr) == ln(a)) || (ln(cand_addr) == WILD_LINE);
  endfunction
  function automatic bit model();
    bit y = 0;
    bit fill = (cand_kind == 3'd5);
    for (int i = 0; i < QD; i++)
      if (q_vld[i] && same(q_addr[i]) && cand_prio > q_prio[i]) y = 1;
    for (int i = 0; i < 2*NM; i++)
      if (miss_vld[i] && same(miss_addr[i]) && cand_prio > miss_prio[i]) y = 1;
    for (int i = 0; i < 2; i++)
      if (ovf_vld[i] && same(ovf_addr[i]) && cand_prio > ovf_prio[i]) y = 1;
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < NS; s++) begin
        int k = p*NS + s;
        if (!stg_vld[k]) continue;
        if (p != int'(cand_pipe) && s == NS-1 && same(stg_addr[k])) y = 1;
        if (!fill && stg_kind[k] == 3'd5) y = 1;
        if (!fill && p == int'(cand_pipe) && same(stg_addr[k]) && cand_prio > stg_prio[k]) y = 1;
      end
    return y;
  endfunction

  // ---------- driver ----------
  task automatic clear_all();
    cand_addr = 32'h0000_1000; cand_prio = 8'd5; cand_kind = 3'd0; cand_pipe = 1'b0;
    q_vld = '0; q_addr = '0; q_prio = '0;
    stg_vld = '0; stg_addr = '0; stg_prio = '0; stg_kind = '0;
    miss_vld = '0; miss_addr = '0; miss_prio = '0;
    ovf_vld = '0; ovf_addr = '0; ovf_prio = '0;
  endtask

  // candidate also occupies its own final stage
  task automatic seat_cand();
    int k = int'(cand_pipe)*NS + NS-1;
    stg_vld[k] = 1'b1; stg_addr[k] = cand_addr; stg_prio[k] = cand_prio; stg_kind[k] = cand_kind;
  endtask

  task automatic apply(input string tag);
    item_t it;
    it.exp = model(); it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
    #1;
  endtask

  // ---------- monitor ----------
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (yield !== it.exp) begin
        errors++;
        $display("FAIL %s yield=%0b expected=%0b", it.tag, yield, it.exp);
      end
    end
  end

  // ---------- watchdog ----------
  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog yield=%0b expected=done", yield);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(posedge clk);
    #1;

    // R9: idle state, nothing valid
    apply("R9 idle");
    seat_cand(); apply("R9 own seat only");

    // R3: queue entries
    q_vld[1] = 1; q_addr[1] = 32'h0000_1000; q_prio[1] = 8'd3;
    apply("R3 same line lower number queued");
    cand_prio = 8'd2; seat_cand(); apply("R3 candidate more urgent");
    cand_prio = 8'd3; seat_cand(); apply("R3 equal priority");
    cand_prio = 8'd5; seat_cand(); q_addr[1] = 32'h0000_1020; apply("R1 next line");
    q_addr[1] = 32'h0000_101F; apply("R1 offset bits ignored");
    q_vld[1] = 0; apply("R9 invalid queue entry");

    // R4: other pipe final stage
    clear_all(); seat_cand();
    stg_vld[2*NS-1] = 1; stg_addr[2*NS-1] = 32'h0000_1004; stg_prio[2*NS-1] = 8'd9;
    apply("R4 other final blocks despite priority");
    stg_addr[2*NS-1] = 32'h0000_2000; apply("R4 other final different line");
    clear_all(); seat_cand();
    stg_vld[NS] = 1; stg_addr[NS] = 32'h0000_1000; stg_prio[NS] = 8'd1;
    apply("R4 other pipe non-final stage no block");
    clear_all(); cand_pipe = 1'b1; seat_cand();
    stg_vld[NS-1] = 1; stg_addr[NS-1] = 32'h0000_1010; stg_prio[NS-1] = 8'd7;
    apply("R4 pipe1 candidate vs pipe0 final");

    // R5: miss-wait entries
    clear_all(); seat_cand();
    miss_vld[3] = 1; miss_addr[3] = 32'h0000_1008; miss_prio[3] = 8'd4;
    apply("R5 other pipe miss entry");
    cand_prio = 8'd4; seat_cand(); apply("R5 equal priority no yield");
    miss_vld[3] = 0; miss_vld[0] = 1; miss_addr[0] = 32'h0000_1000; miss_prio[0] = 8'd1;
    apply("R5 own pipe miss entry");

    // R6: refill anywhere
    clear_all(); seat_cand();
    stg_vld[NS+1] = 1; stg_addr[NS+1] = 32'h0000_8000; stg_kind[NS+1] = 3'd5; stg_prio[NS+1] = 8'd9;
    apply("R6 refill other pipe any address");
    cand_kind = 3'd1; seat_cand(); apply("R6 store candidate blocked");
    cand_kind = 3'd5; seat_cand(); apply("R6 refill candidate exempt");

    // R7: own pipe stages
    clear_all(); seat_cand();
    stg_vld[1] = 1; stg_addr[1] = 32'h0000_1000; stg_prio[1] = 8'd2; stg_kind[1] = 3'd2;
    apply("R7 own stage more urgent");
    cand_kind = 3'd5; seat_cand(); apply("R7 refill candidate exempt");
    cand_kind = 3'd0; seat_cand(); stg_prio[1] = 8'd7; apply("R7 own stage less urgent");

    // R8: overflow entries
    clear_all(); seat_cand();
    ovf_vld[1] = 1; ovf_addr[1] = 32'h0000_1000; ovf_prio[1] = 8'd2;
    apply("R8 overflow same line");
    ovf_prio[1] = 8'd6; apply("R8 overflow less urgent");
    ovf_prio[1] = 8'd2; ovf_vld[1] = 0; apply("R9 overflow invalid");

    // R2: wildcard candidate
    clear_all(); cand_addr = 32'hFFFF_FFE4; seat_cand();
    miss_vld[1] = 1; miss_addr[1] = 32'h0000_4000; miss_prio[1] = 8'd1;
    apply("R2 wildcard hits miss entry");
    miss_vld[1] = 0; q_vld[0] = 1; q_addr[0] = 32'h0000_4000; q_prio[0] = 8'd9;
    apply("R2 wildcard but candidate more urgent");
    clear_all(); cand_addr = 32'hFFFF_FFC0; seat_cand();
    q_vld[0] = 1; q_addr[0] = 32'h0000_4000; q_prio[0] = 8'd1;
    apply("R2 line below all-ones is not wild");

    // R10: output follows inputs without a clock edge
    clear_all(); seat_cand();
    @(posedge clk); #2;
    ovf_vld[0] = 1; ovf_addr[0] = 32'h0000_1000; ovf_prio[0] = 8'd0;
    #1;
    checks++;
    if (yield !== 1'b1) begin
      errors++;
      $display("FAIL R10 yield=%0b expected=1", yield);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule